// File: doc/BRIEF.md
# Slot Power Status and Hot-Swap Register Block

This block sits on a simple host register bus and gives software a view of the supply state of seven adapter slots, a free 32-bit control word, and a latched record of hot-insertion/removal events plus a memory-error flag. Slot 0 is treated as permanently powered. Slots 1 to 6 report both of their supply-good bits whenever the matching slot-present input is high. The supply-good bits of each slot sit at fixed, non-contiguous positions that host software decodes.

Two level interrupts leave the block. The adapter-management interrupt is raised by a pulse on its event input and is dropped by any read or write to the management register. The hot-swap interrupt is raised whenever a hot-swap or memory-error pulse arrives and is dropped by any read or write to the event register. Event bits persist until software writes a 1 to them; a new event on a bit always beats a clear of that bit in the same cycle.

The bus is a single-cycle strobe interface: an 8-bit byte offset, read and write strobes and 32-bit data. Read data is registered: it appears on the clock edge that samples the read strobe and holds until the next read.

Top module: `slot_pwr_hotswap_regs`

## Requirements
- R1: After reset, both interrupts are low, read data is zero, the control word is zero and the event register is zero.
- R2: A read of offset 0x50 always returns bit 1 (slot 0, 3V good) and bit 2 (slot 0, 5V good) set.
- R3: In the offset 0x50 read, slot k (k = 1..6, present input bit k-1) sets its 5V/3V good bits only when present, at bits 9/10 (k=1), 13/14 (k=2), 25/26 (k=3), 17/18 (k=4), 29/30 (k=5), 21/22 (k=6); all other bits read zero, and the value reflects the present inputs at the read edge.
- R4: Offset 0x58 is a 32-bit read/write control word that returns the last written value.
- R5: A read of offset 0x40 returns the offset 0x50 value ANDed with 0x66666600.
- R6: A management event pulse sets the management interrupt on the next edge; any read or write to offset 0x40 clears it, unless a management pulse arrives in the same cycle, in which case it stays set.
- R7: A hot-swap pulse on slot k (input bit k-1) sets bit k of offset 0x70, a memory-error pulse sets bit 7, and any such pulse sets the hot-swap interrupt on the next edge.
- R8: A read of offset 0x70 returns the event bits (bits 0 and 8..31 zero) without changing them, and clears the hot-swap interrupt unless a new event arrives in the same cycle.
- R9: A write to offset 0x70 clears each event bit whose data bit is 1 and clears the hot-swap interrupt; an event setting a bit in the same cycle wins over the clear of that bit and keeps the interrupt set.
- R10: Offset 0x48 reads 0xFFFFFFFF, offset 0x78 reads zero, any unmapped offset reads zero, and writes to offsets other than 0x58 and 0x70 change no readable state.
- R11: Read data updates only on an edge where the read strobe is high and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte offset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| slot_present | input | 6 | Present flag of slots 1..6 (bit 0 = slot 1) |
| swap_evt | input | 6 | Hot-swap event pulse of slots 1..6 (bit 0 = slot 1) |
| memerr_evt | input | 1 | Memory-error event pulse |
| mgmt_evt | input | 1 | Adapter-management event pulse |
| irq_mgmt | output | 1 | Adapter-management interrupt |
| irq_swap | output | 1 | Hot-swap interrupt |

## Verification
The bench walks each slot's present input on its own, because a design that swapped two slots' bit positions would still pass a test with all slots present or absent. It drives a write-one-to-clear of the event register in the same cycle as a new event on the same bit, where a design giving the clear priority would lose the event and drop the interrupt. It also accesses offset 0x40 and 0x70 in the same cycle as a fresh event, and reads 0x70 to confirm that a read-clear design would wrongly erase the event bits. Random traffic over mapped and unmapped offsets catches writes leaking into read-only or unmapped offsets and read data that changes without a read strobe.

// File: rtl/slot_regs_pkg.sv
package slot_regs_pkg;

    localparam int NUM_SLOTS = 7;
    localparam int HOT_SLOTS = NUM_SLOTS - 1;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 8;
    localparam int POS_W     = $clog2(DATA_W);
    localparam int EVT_W     = HOT_SLOTS + 2;   // bit 0 unused, slots 1..6, memory error on top

    localparam logic [DATA_W-1:0] MGMT_VIEW_MASK = 32'h6666_6600;

    localparam logic [ADDR_W-1:0] OFF_MGMT  = 8'h40;
    localparam logic [ADDR_W-1:0] OFF_ONES  = 8'h48;
    localparam logic [ADDR_W-1:0] OFF_PWR   = 8'h50;
    localparam logic [ADDR_W-1:0] OFF_CTRL  = 8'h58;
    localparam logic [ADDR_W-1:0] OFF_EVT   = 8'h70;
    localparam logic [ADDR_W-1:0] OFF_QUIET = 8'h78;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_MGMT,
        SEL_ONES,
        SEL_PWR,
        SEL_CTRL,
        SEL_EVT,
        SEL_QUIET
    } reg_sel_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              rd;
        logic              wr;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    function automatic reg_sel_e decode_off(input logic [ADDR_W-1:0] a);
        case (a)
            OFF_MGMT:  return SEL_MGMT;
            OFF_ONES:  return SEL_ONES;
            OFF_PWR:   return SEL_PWR;
            OFF_CTRL:  return SEL_CTRL;
            OFF_EVT:   return SEL_EVT;
            OFF_QUIET: return SEL_QUIET;
            default:   return SEL_NONE;
        endcase
    endfunction

    // Bit position of the 5V-good flag of a slot.
    function automatic logic [POS_W-1:0] good5_pos(input int slot);
        case (slot)
            1:       return POS_W'(9);
            2:       return POS_W'(13);
            3:       return POS_W'(25);
            4:       return POS_W'(17);
            5:       return POS_W'(29);
            6:       return POS_W'(21);
            default: return POS_W'(2);
        endcase
    endfunction

    // Bit position of the 3V-good flag of a slot.
    function automatic logic [POS_W-1:0] good3_pos(input int slot);
        if (slot == 0)
            return POS_W'(1);
        return good5_pos(slot) + POS_W'(1);
    endfunction

endpackage

// File: rtl/slot_pwr_map.sv
module slot_pwr_map
    import slot_regs_pkg::*;
(
    input  logic [HOT_SLOTS-1:0] present,
    output logic [DATA_W-1:0]    pwr_word
);
    always_comb begin
        pwr_word = '0;
        pwr_word[good3_pos(0)] = 1'b1;
        pwr_word[good5_pos(0)] = 1'b1;
        for (int s = 1; s < NUM_SLOTS; s++) begin
            if (present[s-1]) begin
                pwr_word[good3_pos(s)] = 1'b1;
                pwr_word[good5_pos(s)] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_flag.sv
module irq_flag (
    input  logic clk,
    input  logic rst,
    input  logic raise,
    input  logic ack,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst)
            irq <= 1'b0;
        else if (raise)
            irq <= 1'b1;
        else if (ack)
            irq <= 1'b0;
    end
endmodule

// File: rtl/hotswap_event_latch.sv
module hotswap_event_latch
    import slot_regs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [HOT_SLOTS-1:0] swap_pulse,
    input  logic                 memerr_pulse,
    input  logic                 clr_en,
    input  logic [EVT_W-1:0]     clr_mask,
    output logic [EVT_W-1:0]     evt_bits,
    output logic                 any_set
);
    logic [EVT_W-1:0] set_vec;
    logic [EVT_W-1:0] kept;

    assign set_vec = {memerr_pulse, swap_pulse, 1'b0};
    assign any_set = |set_vec;
    assign kept    = clr_en ? (evt_bits & ~clr_mask) : evt_bits;

    always_ff @(posedge clk) begin
        if (rst)
            evt_bits <= '0;
        else
            evt_bits <= kept | set_vec;
    end
endmodule

// File: rtl/slot_reg_readback.sv
module slot_reg_readback
    import slot_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd,
    input  reg_sel_e          sel,
    input  logic [DATA_W-1:0] pwr_word,
    input  logic [DATA_W-1:0] ctrl_word,
    input  logic [EVT_W-1:0]  evt_bits,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] rd_val;

    always_comb begin
        case (sel)
            SEL_MGMT: rd_val = pwr_word & MGMT_VIEW_MASK;
            SEL_ONES: rd_val = '1;
            SEL_PWR:  rd_val = pwr_word;
            SEL_CTRL: rd_val = ctrl_word;
            SEL_EVT:  rd_val = DATA_W'(evt_bits);
            default:  rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (rd)
            rdata <= rd_val;
    end
endmodule

// File: rtl/slot_pwr_hotswap_regs.sv
module slot_pwr_hotswap_regs
    import slot_regs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_rd,
    input  logic                 bus_wr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [HOT_SLOTS-1:0] slot_present,
    input  logic [HOT_SLOTS-1:0] swap_evt,
    input  logic                 memerr_evt,
    input  logic                 mgmt_evt,
    output logic                 irq_mgmt,
    output logic                 irq_swap
);
    bus_req_t          req;
    reg_sel_e          sel;
    logic              touch;
    logic [DATA_W-1:0] pwr_word;
    logic [DATA_W-1:0] ctrl_word;
    logic [EVT_W-1:0]  evt_bits;
    logic              evt_any;

    assign req   = '{addr: bus_addr, rd: bus_rd, wr: bus_wr, wdata: bus_wdata};
    assign sel   = decode_off(req.addr);
    assign touch = req.rd | req.wr;

    slot_pwr_map u_map (
        .present  (slot_present),
        .pwr_word (pwr_word)
    );

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_word <= '0;
        else if (req.wr && sel == SEL_CTRL)
            ctrl_word <= req.wdata;
    end

    hotswap_event_latch u_evt (
        .clk          (clk),
        .rst          (rst),
        .swap_pulse   (swap_evt),
        .memerr_pulse (memerr_evt),
        .clr_en       (req.wr && sel == SEL_EVT),
        .clr_mask     (req.wdata[EVT_W-1:0]),
        .evt_bits     (evt_bits),
        .any_set      (evt_any)
    );

    irq_flag u_irq_mgmt (
        .clk   (clk),
        .rst   (rst),
        .raise (mgmt_evt),
        .ack   (touch && sel == SEL_MGMT),
        .irq   (irq_mgmt)
    );

    irq_flag u_irq_swap (
        .clk   (clk),
        .rst   (rst),
        .raise (evt_any),
        .ack   (touch && sel == SEL_EVT),
        .irq   (irq_swap)
    );

    slot_reg_readback u_rb (
        .clk       (clk),
        .rst       (rst),
        .rd        (req.rd),
        .sel       (sel),
        .pwr_word  (pwr_word),
        .ctrl_word (ctrl_word),
        .evt_bits  (evt_bits),
        .rdata     (bus_rdata)
    );
endmodule

// File: rtl/slot_regs_chk.sv
module slot_regs_chk
    import slot_regs_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic                 bus_rd,
    input logic                 bus_wr,
    input logic [DATA_W-1:0]    bus_rdata,
    input logic [HOT_SLOTS-1:0] swap_evt,
    input logic                 memerr_evt,
    input logic                 mgmt_evt,
    input logic                 irq_mgmt,
    input logic                 irq_swap
);
    logic hit_mgmt;
    logic hit_evt;
    logic new_evt;

    assign hit_mgmt = (bus_rd || bus_wr) && bus_addr == OFF_MGMT;
    assign hit_evt  = (bus_rd || bus_wr) && bus_addr == OFF_EVT;
    assign new_evt  = (|swap_evt) || memerr_evt;

    // R6
    mgmt_raise_chk: assert property (@(posedge clk) disable iff (rst)
        mgmt_evt |=> irq_mgmt);

    // R6
    mgmt_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (hit_mgmt && !mgmt_evt) |=> !irq_mgmt);

    // R7
    swap_raise_chk: assert property (@(posedge clk) disable iff (rst)
        new_evt |=> irq_swap);

    // R8
    swap_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (hit_evt && !new_evt) |=> !irq_swap);

    // R2
    slot0_good_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == OFF_PWR) |=> bus_rdata[2:1] == 2'b11);

    // R5
    mgmt_view_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == OFF_MGMT) |=> (bus_rdata & ~MGMT_VIEW_MASK) == '0);

    // R10
    ones_read_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == OFF_ONES) |=> bus_rdata == '1);

    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));
endmodule

bind slot_pwr_hotswap_regs slot_regs_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .bus_rdata  (bus_rdata),
    .swap_evt   (swap_evt),
    .memerr_evt (memerr_evt),
    .mgmt_evt   (mgmt_evt),
    .irq_mgmt   (irq_mgmt),
    .irq_swap   (irq_swap)
);

// File: tb/slot_pwr_hotswap_regs_tb_top.sv
module slot_pwr_hotswap_regs_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [5:0]  slot_present = '0;
    logic [5:0]  swap_evt = '0;
    logic        memerr_evt = 1'b0;
    logic        mgmt_evt = 1'b0;
    logic        irq_mgmt;
    logic        irq_swap;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // bench model
    logic [31:0] m_ctrl  = '0;
    logic [7:0]  m_evt   = '0;
    logic        m_mgmt  = 1'b0;
    logic        m_swap  = 1'b0;
    logic [31:0] m_rdata = '0;

    always #2 clk = ~clk;   // 250 MHz

    slot_pwr_hotswap_regs dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .slot_present(slot_present),
        .swap_evt(swap_evt), .memerr_evt(memerr_evt), .mgmt_evt(mgmt_evt),
        .irq_mgmt(irq_mgmt), .irq_swap(irq_swap)
    );

    function automatic logic [31:0] exp_pwr(input logic [5:0] p);
        logic [31:0] v = 32'h0000_0006;
        if (p[0]) v |= 32'h0000_0600;
        if (p[1]) v |= 32'h0000_6000;
        if (p[2]) v |= 32'h0600_0000;
        if (p[3]) v |= 32'h0006_0000;
        if (p[4]) v |= 32'h6000_0000;
        if (p[5]) v |= 32'h0060_0000;
        return v;
    endfunction

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        case (a)
            8'h40:   return exp_pwr(slot_present) & 32'h6666_6600;
            8'h48:   return 32'hFFFF_FFFF;
            8'h50:   return exp_pwr(slot_present);
            8'h58:   return m_ctrl;
            8'h70:   return {24'h0, m_evt};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        case (a)
            8'h40:   return "R5";
            8'h48:   return "R10";
            8'h50:   return "R3";
            8'h58:   return "R4";
            8'h70:   return "R8";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, got, exp);
        end
    endtask

    // One bus cycle with optional event pulses; called and returns at a falling edge.
    task automatic cycle(input bit rd, input bit wr, input logic [7:0] a, input logic [31:0] wd,
                         input logic [5:0] sw, input bit me, input bit mg, input string tag);
        logic [7:0] setv;
        bit         hit;
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
        swap_evt = sw; memerr_evt = me; mgmt_evt = mg;
        if (rd) m_rdata = exp_read(a);
        setv = {me, sw, 1'b0};
        hit  = rd | wr;
        if (wr && a == 8'h58) m_ctrl = wd;
        if (wr && a == 8'h70) m_evt = m_evt & ~wd[7:0];
        m_evt = m_evt | setv;
        if (|setv) m_swap = 1'b1; else if (hit && a == 8'h70) m_swap = 1'b0;
        if (mg) m_mgmt = 1'b1; else if (hit && a == 8'h40) m_mgmt = 1'b0;
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0; swap_evt = '0; memerr_evt = 1'b0; mgmt_evt = 1'b0;
        check(rd ? tag : "R11", bus_rdata, m_rdata);
        check("R6 irq_mgmt", {31'h0, irq_mgmt}, {31'h0, m_mgmt});
        check("R7 irq_swap", {31'h0, irq_swap}, {31'h0, m_swap});
    endtask

    task automatic rd_reg(input logic [7:0] a, input string tag);
        cycle(1'b1, 1'b0, a, 32'h0, 6'h0, 1'b0, 1'b0, tag);
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d, input string tag);
        cycle(1'b0, 1'b1, a, d, 6'h0, 1'b0, 1'b0, tag);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check("R1 rdata", bus_rdata, 32'h0);
        check("R1 irq_mgmt", {31'h0, irq_mgmt}, 32'h0);
        check("R1 irq_swap", {31'h0, irq_swap}, 32'h0);
        rd_reg(8'h58, "R1 ctrl");
        rd_reg(8'h70, "R1 events");

        // R2: nothing present, only slot 0 bits
        rd_reg(8'h50, "R2 slot0 only");
        // R3: walk each slot alone
        for (int s = 0; s < 6; s++) begin
            slot_present = 6'(1 << s);
            rd_reg(8'h50, "R3 single slot");
            rd_reg(8'h40, "R5 single slot");
        end
        slot_present = 6'h3F;
        rd_reg(8'h50, "R3 all present");
        rd_reg(8'h40, "R5 all present");

        // R4: control word
        wr_reg(8'h58, 32'hA5C3_0F81, "R4 write");
        rd_reg(8'h58, "R4 readback");

        // R6: management interrupt set and cleared by write and by read
        cycle(1'b0, 1'b0, 8'h00, 0, 6'h0, 1'b0, 1'b1, "R6 raise");
        wr_reg(8'h40, 32'hFFFF_FFFF, "R6 write clears");
        cycle(1'b0, 1'b0, 8'h00, 0, 6'h0, 1'b0, 1'b1, "R6 raise");
        rd_reg(8'h40, "R6 read clears");
        cycle(1'b1, 1'b0, 8'h40, 0, 6'h0, 1'b0, 1'b1, "R6 event beats ack");

        // R7: events latch
        cycle(1'b0, 1'b0, 8'h00, 0, 6'b000101, 1'b0, 1'b0, "R7 swap");
        cycle(1'b0, 1'b0, 8'h00, 0, 6'h0, 1'b1, 1'b0, "R7 memerr");
        // R8: read returns bits, does not clear them, clears interrupt
        rd_reg(8'h70, "R8 read");
        rd_reg(8'h70, "R8 read again");
        // R8: read while new event keeps interrupt
        cycle(1'b1, 1'b0, 8'h70, 0, 6'b100000, 1'b0, 1'b0, "R8 read with event");
        // R9: set beats clear on same bit
        cycle(1'b0, 1'b1, 8'h70, 32'hFFFF_FFFF, 6'b000100, 1'b0, 1'b0, "R9 set wins");
        rd_reg(8'h70, "R9 survivor");
        wr_reg(8'h70, 32'h0000_0008, "R9 clear");
        rd_reg(8'h70, "R9 empty");

        // R10: fixed and unmapped offsets, writes ignored
        wr_reg(8'h48, 32'h0, "R10 write ones");
        rd_reg(8'h48, "R10 ones");
        wr_reg(8'h78, 32'hFFFF_FFFF, "R10 write quiet");
        rd_reg(8'h78, "R10 quiet");
        wr_reg(8'h50, 32'h0, "R10 write status");
        rd_reg(8'h50, "R10 status untouched");
        wr_reg(8'h7B, 32'h1234_5678, "R10 write unmapped");
        rd_reg(8'h7B, "R10 unmapped");
        rd_reg(8'h58, "R10 ctrl untouched");

        // random traffic
        for (int i = 0; i < 2000; i++) begin
            logic [7:0] a;
            int unsigned k = $urandom_range(0, 8);
            case (k)
                0: a = 8'h40; 1: a = 8'h48; 2: a = 8'h50; 3: a = 8'h58;
                4: a = 8'h70; 5: a = 8'h78; 6: a = 8'h10; 7: a = 8'h70;
                default: a = 8'($urandom);
            endcase
            if ($urandom_range(0, 7) == 0) slot_present = 6'($urandom);
            begin
                int unsigned op = $urandom_range(0, 3);
                logic [5:0] sw = ($urandom_range(0, 3) == 0) ? 6'($urandom) : 6'h0;
                bit me = ($urandom_range(0, 9) == 0);
                bit mg = ($urandom_range(0, 5) == 0);
                cycle(op == 1, op == 2, a, $urandom, sw, me, mg, tag_of(a));
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule